// File: doc/BRIEF.md
# Quarter-Square Table Multiplier

This block multiplies two unsigned operands of `N` bits each, with no multiplier array. It rests on the identity X·Y = ((X+Y)² − (X−Y)²) / 4. A front end forms the sum of the operands and the magnitude of their difference, each `N+1` bits wide. Each of these values addresses its own squaring table, and the tables are filled with constants when the design elaborates. A back end subtracts the smaller square from the larger one and drops the two low bits, which gives the `2N`-bit product. Two tables of 2^(N+1) entries each take the place of a single product table with 2^(2N) entries.

Operands enter and the product leaves on valid/ready streams. An input beat is taken on a rising edge when `in_valid` and `in_ready` are both high. An output beat leaves when `out_valid` and `out_ready` are both high. With `REG_STAGE=1` (the default), one register sits between the table lookup and the back end. The block then holds a single beat. `in_ready` is high when that register is empty or is being drained in the same cycle. A held beat stays unchanged until the consumer takes it. With `REG_STAGE=0` the path is purely combinational: `out_valid` follows `in_valid` and `in_ready` follows `out_ready`.

Top module: `qsm_mult`

## Requirements
- R1: For every pair of unsigned `N`-bit operands, the product delivered for a beat equals X·Y, zero-extended to `2N` bits.
- R2: The operand sum is formed on `N+1` bits, so pairs whose sum exceeds 2^N−1 (for example 63 and 63 at N=6, product 3969) still give the exact product.
- R3: The difference path uses |X−Y|, so a pair with X<Y gives the same correct product as the same pair with X>Y.
- R4: The difference of the two squares always has its two low bits at zero, so the right shift by two discards no set bit.
- R5: With `REG_STAGE=1`, a beat accepted on a rising edge makes `out_valid` high in the following cycle and carries that beat's product.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_product` stays unchanged on the next cycle.
- R7: With `REG_STAGE=1`, `in_ready` is high exactly when `out_valid` is low or `out_ready` is high.
- R8: While `rst_n` is low, and in the first cycle after it is released, `out_valid` is low and `in_ready` is high.
- R9: A zero operand on either side gives a product of zero.
- R10: Beats leave in the order they were accepted, with none lost or duplicated under any pattern of valid gaps and back-pressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand beat present |
| in_ready | output | 1 | Block can take an operand beat |
| in_x | input | N | First unsigned operand |
| in_y | input | N | Second unsigned operand |
| out_valid | output | 1 | Product beat present |
| out_ready | input | 1 | Consumer takes the product beat |
| out_product | output | 2N | Unsigned product |

## Verification
A wrong table word or a wrong difference magnitude shows at `out_product` for the pairs that address it, and does so on the cycle after those pairs are accepted. For that reason the bench applies all 4096 operand pairs and does not sample a subset. A fault in the hold register or in the ready logic shows as a product that changes during a stall, or as a dropped or repeated beat. The bench catches these by checking order against a queue of expected results while it drives random back-pressure.

// File: rtl/qsm_pkg.sv
package qsm_pkg;
  // Square of a small table index, evaluated while the tables elaborate.
  function automatic longint unsigned qsm_square(input longint unsigned v);
    return v * v;
  endfunction
endpackage

// File: rtl/qsm_pre.sv
module qsm_pre #(
  parameter int N = 6,
  localparam int AW = N + 1
) (
  input  logic [N-1:0]  op_a,
  input  logic [N-1:0]  op_b,
  output logic [AW-1:0] sum_addr,
  output logic [AW-1:0] dif_addr
);
  logic a_ge_b;

  always_comb begin
    a_ge_b   = (op_a >= op_b);
    sum_addr = {1'b0, op_a} + {1'b0, op_b};
    if (a_ge_b) dif_addr = {1'b0, op_a} - {1'b0, op_b};
    else        dif_addr = {1'b0, op_b} - {1'b0, op_a};
  end

  // R3: the magnitude never exceeds the sum of the operands
  always_comb begin
    assert_dif_le_sum_R3: assert (dif_addr <= sum_addr);
  end
endmodule

// File: rtl/qsm_square_rom.sv
module qsm_square_rom #(
  parameter int AW = 7,
  localparam int DW = 2 * AW,
  localparam int DEPTH = 1 << AW
) (
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] square
);
  import qsm_pkg::*;

  logic [DW-1:0] table_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    localparam longint unsigned SQ = qsm_square(longint'(i));
    assign table_q[i] = DW'(SQ);
  end

  assign square = table_q[addr];
endmodule

// File: rtl/qsm_post.sv
module qsm_post #(
  parameter int N = 6,
  localparam int DW = 2 * (N + 1),
  localparam int PW = 2 * N
) (
  input  logic [DW-1:0] sq_sum,
  input  logic [DW-1:0] sq_dif,
  output logic [PW-1:0] product
);
  logic [DW-1:0] delta;

  always_comb begin
    delta   = sq_sum - sq_dif;
    product = delta[DW-1:2];
  end

  // R4: the two squares always differ by a multiple of four
  always_comb begin
    assert_delta_mult4_R4: assert (delta[1:0] == 2'b00);
    assert_sum_ge_dif_R1: assert (sq_sum >= sq_dif);
  end
endmodule

// File: rtl/qsm_mult.sv
module qsm_mult #(
  parameter int N = 6,
  parameter bit REG_STAGE = 1'b1,
  localparam int AW = N + 1,
  localparam int DW = 2 * AW,
  localparam int PW = 2 * N
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [N-1:0]  in_x,
  input  logic [N-1:0]  in_y,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [PW-1:0] out_product
);
  logic [AW-1:0] sum_addr, dif_addr;
  logic [DW-1:0] sq_sum, sq_dif;
  logic [DW-1:0] post_sum, post_dif;

  qsm_pre #(.N(N)) u_pre (
    .op_a(in_x), .op_b(in_y), .sum_addr(sum_addr), .dif_addr(dif_addr)
  );

  qsm_square_rom #(.AW(AW)) u_rom_sum (.addr(sum_addr), .square(sq_sum));
  qsm_square_rom #(.AW(AW)) u_rom_dif (.addr(dif_addr), .square(sq_dif));

  if (REG_STAGE) begin : g_reg
    logic          hold_q;
    logic [DW-1:0] sum_q, dif_q;
    logic          take;

    assign in_ready  = !hold_q || out_ready;
    assign take      = in_valid && in_ready;
    assign out_valid = hold_q;
    assign post_sum  = sum_q;
    assign post_dif  = dif_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hold_q <= 1'b0;
      end else if (take) begin
        hold_q <= 1'b1;
      end else if (out_ready) begin
        hold_q <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (take) begin
        sum_q <= sq_sum;
        dif_q <= sq_dif;
      end
    end

    // R5: an accepted beat is presented on the next cycle
    assert_accept_to_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);

    // R5: the presented product is the one for the accepted operands
    assert_product_matches_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (out_product == PW'($past(in_x) * $past(in_y))));

    // R6: a stalled beat holds its value
    assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_product)));

    // R8: the first cycle after reset is empty
    assert_empty_after_reset_R8: assert property (@(posedge clk)
      !rst_n |=> (!out_valid && in_ready));
  end else begin : g_comb
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign post_sum  = sq_sum;
    assign post_dif  = sq_dif;
  end

  qsm_post #(.N(N)) u_post (
    .sq_sum(post_sum), .sq_dif(post_dif), .product(out_product)
  );
endmodule

// File: tb/qsm_mult_test.sv
module qsm_mult_test;
  localparam int N  = 6;
  localparam int PW = 2 * N;
  localparam int NPAIRS = 1 << (2 * N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [N-1:0]  in_x = '0;
  logic [N-1:0]  in_y = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [PW-1:0] out_product;

  int n_checks = 0;
  int n_errors = 0;

  always #10 clk = ~clk;

  qsm_mult #(.N(N), .REG_STAGE(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_x(in_x), .in_y(in_y), .out_valid(out_valid), .out_ready(out_ready),
    .out_product(out_product)
  );

  function automatic logic [PW-1:0] ref_product(input logic [N-1:0] a, input logic [N-1:0] b);
    return PW'(a) * PW'(b);
  endfunction

  function automatic string tag_of(input logic [N-1:0] a, input logic [N-1:0] b);
    if (a == 0 || b == 0) return "R9";
    if (int'(a) + int'(b) >= (1 << N)) return "R2";
    if (a < b) return "R3";
    return "R1";
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  logic [N-1:0]  qx [$];
  logic [N-1:0]  qy [$];
  logic [N-1:0]  src_x [$];
  logic [N-1:0]  src_y [$];
  bit            done = 1'b0;

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin : main
    int unsigned seed;
    int received;
    bit prev_stall;
    logic [PW-1:0] prev_prod;
    bit prev_take;
    seed = $urandom(32'h5eed_1234);
    received = 0;
    prev_stall = 1'b0;
    prev_prod = '0;
    prev_take = 1'b0;

    // directed corners first, then every pair
    src_x.push_back(0);  src_y.push_back(0);
    src_x.push_back(63); src_y.push_back(63);
    src_x.push_back(63); src_y.push_back(0);
    src_x.push_back(0);  src_y.push_back(63);
    src_x.push_back(5);  src_y.push_back(60);
    src_x.push_back(60); src_y.push_back(5);
    src_x.push_back(1);  src_y.push_back(1);
    for (int i = 0; i < NPAIRS; i++) begin
      src_x.push_back(N'(i >> N));
      src_y.push_back(N'(i));
    end

    // R8: reset state
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R8", out_valid, 0);
    check(in_ready == 1'b1, "R8", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R8", out_valid, 0);
    check(in_ready == 1'b1, "R8", in_ready, 1);

    while (src_x.size() > 0 || qx.size() > 0) begin
      logic [N-1:0] ex, ey;
      // R5: a beat taken at the last edge is presented now
      if (prev_take) check(out_valid == 1'b1, "R5", out_valid, 1);
      // R6: stalled beat held
      if (prev_stall) begin
        check(out_valid == 1'b1, "R6", out_valid, 1);
        check(out_product == prev_prod, "R6", out_product, prev_prod);
      end
      out_ready = ($urandom % 4) != 0;
      if (src_x.size() > 0 && ($urandom % 5) != 0) begin
        in_valid = 1'b1;
        in_x = src_x[0];
        in_y = src_y[0];
      end else begin
        in_valid = 1'b0;
        in_x = N'($urandom);
        in_y = N'($urandom);
      end
      #1;
      // R7: ready rule
      check(in_ready == (!out_valid || out_ready), "R7", in_ready, !out_valid || out_ready);
      if (out_valid && out_ready) begin
        if (qx.size() == 0) begin
          check(1'b0, "R10", out_product, -1);
        end else begin
          ex = qx.pop_front();
          ey = qy.pop_front();
          check(out_product == ref_product(ex, ey), tag_of(ex, ey),
                out_product, ref_product(ex, ey));
          received++;
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_prod  = out_product;
      prev_take  = in_valid && in_ready;
      if (in_valid && in_ready) begin
        qx.push_back(src_x.pop_front());
        qy.push_back(src_y.pop_front());
      end
      @(negedge clk);
    end

    // R10: every beat came out exactly once
    check(received == NPAIRS + 7, "R10", received, NPAIRS + 7);
    in_valid = 1'b0;
    out_ready = 1'b1;
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0, "R10", out_valid, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule